// File: doc/BRIEF.md
# Shadowed SRAM with Store and Recall

This block is a synchronous behavioural model of a byte-wide static memory in which every word has a nonvolatile shadow word behind it. In normal operation it answers an SRAM-style port: active-low chip enable, output enable and write enable, an address, write data in, and read data out with a separate drive-enable that stands in for a bidirectional bus. Every strobe is sampled on the rising clock edge. Read data and its drive-enable are combinational from the current inputs.

The second mode moves data between the two arrays all at once. A STORE copies the working array into the shadow array. A RECALL first clears the working array to zero and then loads it from the shadow array. A STORE starts on a falling power-good, on a falling edge of the store request pin, or after a software sequence of reads. A RECALL starts on a rising power-good or after a second software sequence. While a transfer runs, the busy output is held low for a parameterised number of clocks, and the memory port is locked out.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, busy_n is 1, dout_oe is 0, both arrays hold zero, the sequence matcher is at step 0, power-good is taken as previously low, and the store pin is taken as previously high.
- R2: When idle, with ce_n=0 and we_n=0 at a clock edge, din is written to the working word at addr. dout_oe is 0 during a write. With ce_n=1, nothing is written.
- R3: When idle, with ce_n=0, we_n=1 and oe_n=0, dout_oe is 1 and dout equals the working word at addr in the same cycle. With ce_n=1 or oe_n=1, dout_oe is 0.
- R4: A power-good fall (previous sample 1, current 0) seen while idle starts a STORE. The shadow array receives a full copy of the working array, and busy_n is 0 for exactly STORE_CYCLES cycles, starting in the next cycle.
- R5: A falling edge on store_req_n (previous sample 1, current 0) seen while idle starts a STORE with the same effect and timing as R4.
- R6: A read access is ce_n=0 with we_n=1, whatever oe_n is. Six consecutive read accesses to SEQ0, SEQ1, SEQ2, SEQ3, SEQ4 (defaults 3, C, 5, A, 6 hex) and then SEQ_STORE (default F) start a STORE. Ending the same run with SEQ_RECALL (default 9) instead starts a RECALL.
- R7: A write, or a read access whose address does not match the expected step, returns the matcher to step 0 and starts nothing. A mismatching address is not itself taken as a first step. Idle cycles with ce_n=1 do not disturb the matcher.
- R8: A power-good rise seen while idle, or a software recall, starts a RECALL. busy_n is 0 for exactly RECALL_CYCLES cycles, after which the working array equals the shadow array. The shadow array is unchanged, so repeated RECALLs give the same result.
- R9: While busy_n is 0, writes and reads are ignored, dout_oe stays 0, the matcher stays at step 0, and new triggers are dropped.
- R10: When several triggers arrive at the same edge, any STORE trigger wins over a RECALL trigger. A write presented in the cycle that starts a transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, valid while dout_oe is 1 |
| dout_oe | output | 1 | Data bus drive enable; 0 means the bus floats |
| store_req_n | input | 1 | Store request pin; a falling edge requests a STORE |
| busy_n | output | 1 | Low while a STORE or RECALL runs |
| pwr_good | input | 1 | Power-good; a fall triggers a STORE, a rise triggers a RECALL |

## Verification
Full-array patterns are written, stored through each of the three STORE triggers, and then overwritten, so that only a correct RECALL can bring the old values back. This separates a working array that was really restored from one that simply kept its contents. Software sequences are sent complete, broken by a write, broken by a wrong read, and ended with an address that matches neither action, which separates a correct matcher reset from a matcher that is too permissive. Writes, reads and triggers are also presented during busy windows and in the same cycle as a trigger, to show lockout and trigger priority at the ports.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int ADDR_W        = 4,
  parameter int STORE_CYCLES  = 20,
  parameter int RECALL_CYCLES = 8,
  parameter logic [ADDR_W-1:0] SEQ0       = 'h3,
  parameter logic [ADDR_W-1:0] SEQ1       = 'hC,
  parameter logic [ADDR_W-1:0] SEQ2       = 'h5,
  parameter logic [ADDR_W-1:0] SEQ3       = 'hA,
  parameter logic [ADDR_W-1:0] SEQ4       = 'h6,
  parameter logic [ADDR_W-1:0] SEQ_STORE  = 'hF,
  parameter logic [ADDR_W-1:0] SEQ_RECALL = 'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  input  logic              store_req_n,
  output logic              busy_n,
  input  logic              pwr_good
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RECALL} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step;
  logic             pg_q, sreq_q;
  logic [7:0]       work_mem   [DEPTH];
  logic [7:0]       shadow_mem [DEPTH];

  function automatic logic [ADDR_W-1:0] seq_at(input logic [2:0] s);
    case (s)
      3'd1:    return SEQ1;
      3'd2:    return SEQ2;
      3'd3:    return SEQ3;
      3'd4:    return SEQ4;
      default: return SEQ0;
    endcase
  endfunction

  wire idle      = (state == ST_IDLE);
  wire pwr_fall  = pg_q & ~pwr_good;
  wire pwr_rise  = ~pg_q & pwr_good;
  wire pin_fall  = sreq_q & ~store_req_n;
  wire rd_acc    = idle & ~ce_n & we_n;
  wire wr_acc    = idle & ~ce_n & ~we_n;
  wire seq_last  = rd_acc && (step == 3'd5);
  wire sw_store  = seq_last && (addr == SEQ_STORE);
  wire sw_recall = seq_last && (addr == SEQ_RECALL);
  wire go_store  = idle & (pwr_fall | pin_fall | sw_store);
  wire go_recall = idle & ~go_store & (pwr_rise | sw_recall);
  wire wr_hit    = wr_acc & ~go_store & ~go_recall;
  wire [2:0] next_step = (step < 3'd5 && addr == seq_at(step)) ? step + 3'd1 : 3'd0;

  assign busy_n  = idle;
  assign dout_oe = idle & ~ce_n & we_n & ~oe_n;
  assign dout    = dout_oe ? work_mem[addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      step   <= 3'd0;
      pg_q   <= 1'b0;
      sreq_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        work_mem[i]   <= 8'h00;
        shadow_mem[i] <= 8'h00;
      end
    end else begin
      pg_q   <= pwr_good;
      sreq_q <= store_req_n;
      if (idle) begin
        if (go_store) begin
          shadow_mem <= work_mem;
          state      <= ST_STORE;
          cnt        <= CNT_W'(STORE_CYCLES - 1);
          step       <= 3'd0;
        end else if (go_recall) begin
          for (int i = 0; i < DEPTH; i++) work_mem[i] <= 8'h00;
          state <= ST_RECALL;
          cnt   <= CNT_W'(RECALL_CYCLES - 1);
          step  <= 3'd0;
        end else if (wr_hit) begin
          work_mem[addr] <= din;
          step           <= 3'd0;
        end else if (rd_acc) begin
          step <= next_step;
        end
      end else if (cnt == '0) begin
        if (state == ST_RECALL) work_mem <= shadow_mem;
        state <= ST_IDLE;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> work_mem[$past(addr)] == $past(din)); // R2
  AST_PWR_FALL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_fall) |=> (state == ST_STORE && !busy_n)); // R4
  AST_PIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pin_fall) |=> (state == ST_STORE)); // R5
  AST_STORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    go_store |=> shadow_mem[$past(addr)] == $past(work_mem[addr])); // R4
  AST_RISE_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_rise && !pin_fall) |=> (state == ST_RECALL)); // R8
  AST_SHADOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECALL) |=> shadow_mem[$past(addr)] == $past(shadow_mem[addr])); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cnt != '0) |=> !busy_n); // R9
  AST_STORE_LOCKS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STORE) |=> work_mem[$past(addr)] == $past(work_mem[addr])); // R9
  AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pin_fall && (pwr_rise || sw_recall)) |=> (state == ST_STORE)); // R10
endmodule

// File: tb/nvsram_ctrl_tb.sv
module nvsram_ctrl_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int SC = 20;
  localparam int RC = 8;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe, busy_n;
  logic store_req_n = 1, pwr_good = 0;

  always #5 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(AW), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .store_req_n(store_req_n), .busy_n(busy_n), .pwr_good(pwr_good));

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  int seqv[6] = '{3, 12, 5, 10, 6, 15};

  int mw[DEPTH], ms[DEPTH];
  int mst, mcnt, mstep;
  bit mpg, msreq, pf, pr, sf, rd, wr, swst, swrc;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mw[i]) begin mw[i] = 0; ms[i] = 0; end
      mst = 0; mcnt = 0; mstep = 0; mpg = 0; msreq = 1;
    end else begin
      pf = mpg && !pwr_good;
      pr = !mpg && pwr_good;
      sf = msreq && !store_req_n;
      rd = (mst == 0) && !ce_n && we_n;
      wr = (mst == 0) && !ce_n && !we_n;
      swst = rd && mstep == 5 && int'(addr) == 15;
      swrc = rd && mstep == 5 && int'(addr) == 9;
      if (mst == 0) begin
        if (pf || sf || swst) begin
          foreach (ms[i]) ms[i] = mw[i];
          mst = 1; mcnt = SC; mstep = 0;
        end else if (pr || swrc) begin
          foreach (mw[i]) mw[i] = 0;
          mst = 2; mcnt = RC; mstep = 0;
        end else if (wr) begin
          mw[addr] = int'(din); mstep = 0;
        end else if (rd) begin
          mstep = (mstep < 5 && int'(addr) == seqv[mstep]) ? mstep + 1 : 0;
        end
      end else begin
        mcnt--;
        if (mcnt == 0) begin
          if (mst == 2) foreach (mw[i]) mw[i] = ms[i];
          mst = 0;
        end
      end
      mpg = pwr_good;
      msreq = store_req_n;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit o, input bit w, input int a, input int d,
                     input bit sr = 1, input bit pg = 1);
    bit eoe;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = AW'(a); din = 8'(d);
    store_req_n = sr; pwr_good = pg;
    #1;
    eoe = (mst == 0) && !c && w && !o;
    check("busy_n", int'(busy_n), int'(mst == 0));
    check("dout_oe", int'(dout_oe), int'(eoe));
    if (eoe) check("dout", int'(dout), mw[a]);
  endtask

  task automatic idle_n(input int n, input bit pg = 1);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, 0, 1, pg);
  endtask

  task automatic write_all(input int seed);
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, (i * 37 + seed) & 255);
  endtask

  task automatic read_all();
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0);
  endtask

  task automatic sw_seq(input int last);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, seqv[i], 0);
    cyc(0, 0, 1, last, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; idle_n(2, 0);
    cur_req = "R2"; for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, i, i + 1, 1, 0);
    cur_req = "R3"; for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i, 0, 1, 0);
    cyc(1, 0, 0, 2, 8'hEE, 1, 0);
    cyc(0, 1, 1, 2, 0, 1, 0);
    cyc(1, 0, 1, 2, 0, 1, 0);
    cur_req = "R2"; cyc(0, 0, 1, 2, 0, 1, 0);
    cur_req = "R8"; cyc(1, 1, 1, 0, 0, 1, 1);
    idle_n(RC + 2); read_all();
    cur_req = "R4"; write_all(11);
    cyc(1, 1, 1, 0, 0, 1, 0);
    cur_req = "R9";
    for (int i = 0; i < SC / 2; i++) cyc(0, 0, 0, i & 15, 8'h77, i[0], 0);
    idle_n(SC, 0);
    read_all();
    write_all(200);
    cur_req = "R8"; cyc(1, 1, 1, 0, 0, 1, 1);
    idle_n(RC + 2); read_all();
    cur_req = "R5"; write_all(90);
    cyc(0, 1, 0, 4, 8'h33, 0);
    idle_n(SC + 2);
    read_all(); write_all(7);
    cur_req = "R6"; sw_seq(9);
    idle_n(RC + 2); read_all();
    cur_req = "R8"; write_all(50); sw_seq(9);
    idle_n(RC + 2); read_all();
    cur_req = "R6"; write_all(123); sw_seq(15);
    idle_n(SC + 2); write_all(1); sw_seq(9); idle_n(RC + 2); read_all();
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, seqv[i], 0);
    cyc(0, 1, 0, 1, 8'h44);
    cyc(0, 0, 1, seqv[3], 0); cyc(0, 0, 1, seqv[4], 0); cyc(0, 0, 1, 15, 0);
    idle_n(3);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, seqv[i], 0);
    cyc(0, 1, 1, 3, 0);
    cyc(0, 0, 1, seqv[4], 0); cyc(0, 0, 1, 9, 0);
    idle_n(3);
    for (int i = 0; i < 2; i++) begin cyc(0, 0, 1, seqv[i], 0); idle_n(2); end
    for (int i = 2; i < 5; i++) cyc(0, 0, 1, seqv[i], 0);
    cyc(0, 0, 1, 7, 0);
    cyc(0, 0, 1, 9, 0);
    idle_n(3); read_all();
    cur_req = "R10"; write_all(60);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, seqv[i], 0);
    cyc(0, 0, 1, 9, 0, 0);
    idle_n(SC + 2); write_all(3);
    sw_seq(9); idle_n(RC + 2); read_all();
    cyc(1, 1, 1, 0, 0, 1, 0);
    cyc(0, 1, 0, 5, 8'hAB, 1, 1);
    idle_n(RC + 2); read_all();
    finish_run();
  end
endmodule